// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a single-port synchronous SRAM. Reads and writes can follow each other on every clock with no idle cycle between them. Every address, select and control input is captured on the rising clock edge. Write data trails its address by a fixed number of cycles. While a write waits for its data, a read of the same word must still see the new bytes, so the model forwards the pending write data into the read path.

A static mode input picks one of two read styles. In registered-read mode the read data passes through an output register, and write data comes two edges after its address. In flow-through mode the read data comes straight from the array, and write data comes one edge after its address. Three active-high selects must all be high to begin an access. A burst-advance input steps the two low address bits, in wrapping linear order or in XOR order. The output enable and the sleep input act on the data outputs without waiting for a clock. The tri-state bus is modelled as a data output with a separate drive flag, and the data output reads zero while it is not driven.

Top module: `zt_sram_model`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge) no access is in flight, `rdata_oe` is 0 and `rdata` is 0.
- R2: With `flow_mode`=0, read data for an access captured at edge N is driven from just after edge N+1 until edge N+2. Between edge N and edge N+1 the output is not driven.
- R3: With `flow_mode`=1, read data for an access captured at edge N is driven from just after edge N until edge N+1.
- R4: Write data on `wdata` is captured at edge N+2 after a write address taken at edge N when `flow_mode`=0, and at edge N+1 when `flow_mode`=1. Values on `wdata` at any other edge are not stored.
- R5: Read and write accesses may be issued on consecutive edges in either order. A read that overlaps a pending write to the same word returns the pending bytes merged with the stored bytes.
- R6: `byte_en` bit i enables write lane i, which is `wdata` bits [9i+8:9i]. Lanes with a clear bit keep their stored value.
- R7: An access starts only when `sel_a`, `sel_b` and `sel_c` are all 1 and `adv` is 0. Otherwise the edge is a deselect: nothing is written and nothing is driven.
- R8: With `interleave`=0, each edge with `adv`=1 during an active access moves to the next beat. The low two address bits become (start + beat) mod 4 and the upper bits stay fixed.
- R9: With `interleave`=1, the burst beat's low two address bits are the start bits XOR the beat count (0,1,2,3).
- R10: `oe_n`=1 forces `rdata_oe` to 0 and `rdata` to 0 at once, without waiting for a clock edge.
- R11: While `sleep`=1, no new access or burst beat is accepted, and the outputs are not driven, with immediate effect.
- R12: An edge with `clk_en`=0 changes no pipeline register, so an access that has already been issued is delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| clk_en | input | 1 | Clock enable; 0 freezes all pipeline state |
| flow_mode | input | 1 | Static: 1 flow-through reads, 0 registered reads |
| interleave | input | 1 | Static burst order: 1 XOR, 0 linear |
| sel_a | input | 1 | Select, active high |
| sel_b | input | 1 | Select, active high |
| sel_c | input | 1 | Select, active high |
| wr_en | input | 1 | 1 write, 0 read for a new access |
| adv | input | 1 | Advance the current burst by one beat |
| addr | input | ADDR_W | Word address of a new access |
| byte_en | input | NBYTES | Per-lane write enables, taken with the address |
| wdata | input | NBYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| rdata | output | NBYTES*BYTE_W | Read data, zero while not driven |
| rdata_oe | output | 1 | 1 while the read data is driven |

## Verification
The hardest case is a write followed at once by a read of the same word in registered-read mode. A model without forwarding returns the old word there, and a model that forwards whole words ignores the byte enables of the pending write. The bench sends write data one cycle early and one cycle late around the correct slot. A mis-timed late-write stage stores the wrong word. Burst reads starting from an odd offset tell the linear order from the XOR order, since a model with the two orders swapped returns the beats in the wrong order. The bench also moves `oe_n` and `sleep` in the middle of a cycle and stalls `clk_en`. A design that registered these inputs, or let the output register load during a stall, shows the drive flag changing in the wrong cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // What a sampled edge does to the access pipeline
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_START = 2'd1,
        OP_NEXT  = 2'd2
    } op_e;

    // Low two word-address bits of a burst beat
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       xor_order);
        logic [1:0] res;
        if (xor_order) res = start ^ beat;
        else           res = start + beat;
        return res;
    endfunction

endpackage

// File: rtl/zt_cmd_ctrl.sv
module zt_cmd_ctrl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic              interleave,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c,
    input  logic              wr_en,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_en,
    output logic              acc_vld,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [NBYTES-1:0] acc_be
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        start_lo;
        logic [1:0]        beat;
        logic [NBYTES-1:0] be;
    } ctrl_t;

    ctrl_t st_d, st_q;
    op_e   op;
    logic [1:0] nxt_beat;
    logic [HI_W-1:0] page;

    always_comb begin
        op = OP_IDLE;
        if (!sleep) begin
            if (adv) begin
                if (st_q.vld) op = OP_NEXT;
            end else if (sel_a && sel_b && sel_c) begin
                op = OP_START;
            end
        end

        nxt_beat = st_q.beat + 2'd1;
        page     = st_q.addr[ADDR_W-1:2];

        st_d = st_q;
        if (clk_en) begin
            case (op)
                OP_START: begin
                    st_d.vld      = 1'b1;
                    st_d.wr       = wr_en;
                    st_d.addr     = addr;
                    st_d.start_lo = addr[1:0];
                    st_d.beat     = 2'd0;
                    st_d.be       = byte_en;
                end
                OP_NEXT: begin
                    st_d.beat = nxt_beat;
                    st_d.addr = {page, beat_offset(st_q.start_lo, nxt_beat, interleave)};
                    st_d.be   = byte_en;
                end
                default: begin
                    st_d.vld = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_vld  = st_q.vld;
    assign acc_wr   = st_q.wr;
    assign acc_addr = st_q.addr;
    assign acc_be   = st_q.be;

endmodule

// File: rtl/zt_data_array.sv
module zt_data_array #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     flow_mode,
    input  logic                     acc_vld,
    input  logic                     acc_wr,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [NBYTES-1:0]        acc_be,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rd_word
);

    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    // Second stage: a write waiting one more edge for its data
    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] be;
    } pend_t;

    pend_t pend_d, pend_q;
    logic [DATA_W-1:0] mem [DEPTH];

    logic              commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_be;
    logic              fwd_hit;

    always_comb begin
        pend_d = pend_q;
        if (clk_en) begin
            pend_d.vld  = acc_vld;
            pend_d.wr   = acc_wr;
            pend_d.addr = acc_addr;
            pend_d.be   = acc_be;
        end

        if (flow_mode) begin
            commit  = clk_en && acc_vld && acc_wr;
            wr_addr = acc_addr;
            wr_be   = acc_be;
        end else begin
            commit  = clk_en && pend_q.vld && pend_q.wr;
            wr_addr = pend_q.addr;
            wr_be   = pend_q.be;
        end

        fwd_hit = !flow_mode && pend_q.vld && pend_q.wr && (pend_q.addr == acc_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NBYTES; b++) begin
            if (commit && wr_be[b]) begin
                mem[wr_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Lane-wise merge of the pending write into the read word
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign rd_word[b*BYTE_W +: BYTE_W] = (fwd_hit && pend_q.be[b])
                                           ? wdata[b*BYTE_W +: BYTE_W]
                                           : mem[acc_addr][b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/zt_read_out.sv
module zt_read_out #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              flow_mode,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } oreg_t;

    oreg_t o_d, o_q;
    logic              have;
    logic [DATA_W-1:0] word;

    always_comb begin
        o_d = o_q;
        if (clk_en) begin
            o_d.vld  = acc_vld && !acc_wr;
            o_d.data = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    always_comb begin
        if (flow_mode) begin
            have = acc_vld && !acc_wr;
            word = rd_word;
        end else begin
            have = o_q.vld;
            word = o_q.data;
        end
        rdata_oe = have && !oe_n && !sleep;
        rdata    = rdata_oe ? word : '0;
    end

endmodule

// File: rtl/zt_sram_model.sv
module zt_sram_model #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     flow_mode,
    input  logic                     interleave,
    input  logic                     sel_a,
    input  logic                     sel_b,
    input  logic                     sel_c,
    input  logic                     wr_en,
    input  logic                     adv,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        byte_en,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     oe_n,
    input  logic                     sleep,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rdata_oe
);

    localparam int DATA_W = NBYTES * BYTE_W;

    logic              acc_vld;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [NBYTES-1:0] acc_be;
    logic [DATA_W-1:0] rd_word;

    zt_cmd_ctrl #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .sleep      (sleep),
        .interleave (interleave),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .sel_c      (sel_c),
        .wr_en      (wr_en),
        .adv        (adv),
        .addr       (addr),
        .byte_en    (byte_en),
        .acc_vld    (acc_vld),
        .acc_wr     (acc_wr),
        .acc_addr   (acc_addr),
        .acc_be     (acc_be)
    );

    zt_data_array #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .flow_mode (flow_mode),
        .acc_vld   (acc_vld),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_be    (acc_be),
        .wdata     (wdata),
        .rd_word   (rd_word)
    );

    zt_read_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .flow_mode (flow_mode),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .acc_vld   (acc_vld),
        .acc_wr    (acc_wr),
        .rd_word   (rd_word),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              sleep,
    input logic              oe_n,
    input logic              adv,
    input logic              sel_a,
    input logic              sel_b,
    input logic              sel_c,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              acc_vld,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rdata_oe
);

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && !adv && sel_a && sel_b && sel_c)
        |=> (acc_vld && acc_addr == $past(addr) && acc_wr == $past(wr_en)));

    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && !(sel_a && sel_b && sel_c)) |=> !acc_vld);

    p_sleep_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sleep) |=> !acc_vld);

    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_oe);

    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(acc_vld) && $stable(acc_wr) && $stable(acc_addr)));

    p_burst_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv && acc_vld)
        |=> (acc_vld && acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

endmodule

bind zt_sram_model zt_sram_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sleep    (sleep),
    .oe_n     (oe_n),
    .adv      (adv),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .sel_c    (sel_c),
    .wr_en    (wr_en),
    .addr     (addr),
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .rdata_oe (rdata_oe)
);

// File: tb/test_zt_sram_model.sv
module test_zt_sram_model;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        flow_mode = 1'b0;
    logic        interleave = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic        wr_en = 1'b0;
    logic        adv = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  byte_en = '0;
    logic [17:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [17:0] rdata;
    logic        rdata_oe;

    int total = 0;
    int bad   = 0;

    localparam logic [2:0] ALL = 3'b111;
    localparam logic [2:0] NON = 3'b000;

    always #4 clk = ~clk;

    zt_sram_model i_zt_sram_model (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .flow_mode  (flow_mode),
        .interleave (interleave),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .sel_c      (sel_c),
        .wr_en      (wr_en),
        .adv        (adv),
        .addr       (addr),
        .byte_en    (byte_en),
        .wdata      (wdata),
        .oe_n       (oe_n),
        .sleep      (sleep),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: inputs set at a falling edge, returns at the next falling edge
    task automatic tick(input logic [2:0] s, input logic w, input logic a,
                        input logic [7:0] ad, input logic [1:0] be, input logic [17:0] wd);
        {sel_a, sel_b, sel_c} = s;
        wr_en   = w;
        adv     = a;
        addr    = ad;
        byte_en = be;
        wdata   = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop(input logic [17:0] wd);
        tick(NON, 1'b0, 1'b0, 8'h00, 2'b00, wd);
    endtask

    task automatic t_reset;
        chk("R1 drive flag after reset", {17'd0, rdata_oe}, 18'd0);
        chk("R1 data after reset", rdata, 18'd0);
    endtask

    task automatic t_pipe_basic;
        flow_mode = 1'b0;
        tick(ALL, 1'b1, 1'b0, 8'h10, 2'b11, 18'h0);
        nop(18'h0);
        nop(18'h2A5A5);
        tick(ALL, 1'b0, 1'b0, 8'h10, 2'b11, 18'h0);
        chk("R2 not driven in access cycle", {17'd0, rdata_oe}, 18'd0);
        nop(18'h0);
        chk("R2 driven one edge later", {17'd0, rdata_oe}, 18'd1);
        chk("R2 registered read data", rdata, 18'h2A5A5);
        nop(18'h0);
        chk("R2 drive lasts one cycle", {17'd0, rdata_oe}, 18'd0);
        // R4: data slot is two edges after the address
        tick(ALL, 1'b1, 1'b0, 8'h11, 2'b11, 18'h0);
        nop(18'h3FFFF);
        nop(18'h12345);
        nop(18'h3FFFF);
        tick(ALL, 1'b0, 1'b0, 8'h11, 2'b11, 18'h0);
        nop(18'h0);
        chk("R4 double late write slot", rdata, 18'h12345);
        nop(18'h0);
    endtask

    task automatic t_pipe_fwd;
        logic [17:0] old_w, new_w, merged, v21;
        flow_mode = 1'b0;
        old_w  = {9'h1AA, 9'h055};
        new_w  = {9'h1FF, 9'h0C3};
        merged = {9'h1AA, 9'h0C3};
        v21    = 18'h0BEEF;
        tick(ALL, 1'b1, 1'b0, 8'h20, 2'b11, 18'h0);
        nop(18'h0);
        nop(old_w);
        // write then read of the same word on back-to-back edges
        tick(ALL, 1'b1, 1'b0, 8'h20, 2'b01, 18'h0);
        tick(ALL, 1'b0, 1'b0, 8'h20, 2'b11, 18'h0);
        nop(new_w);
        chk("R5 forwarding drive", {17'd0, rdata_oe}, 18'd1);
        chk("R5 pending bytes merged into read", rdata, merged);
        // read then write on back-to-back edges
        tick(ALL, 1'b0, 1'b0, 8'h20, 2'b11, 18'h0);
        tick(ALL, 1'b1, 1'b0, 8'h21, 2'b11, 18'h0);
        chk("R5 read before write returns committed merge", rdata, merged);
        nop(18'h0);
        nop(v21);
        tick(ALL, 1'b0, 1'b0, 8'h21, 2'b11, 18'h0);
        nop(18'h0);
        chk("R5 write after read stored", rdata, v21);
        nop(18'h0);
    endtask

    task automatic t_flow;
        flow_mode = 1'b1;
        tick(ALL, 1'b1, 1'b0, 8'h40, 2'b11, 18'h0);
        tick(ALL, 1'b0, 1'b0, 8'h40, 2'b11, 18'h15A5A);
        chk("R3 flow drive in access cycle", {17'd0, rdata_oe}, 18'd1);
        chk("R3 R4 single late write read back", rdata, 18'h15A5A);
        nop(18'h0);
        chk("R3 flow drive ends after one cycle", {17'd0, rdata_oe}, 18'd0);
    endtask

    task automatic t_bytes;
        flow_mode = 1'b1;
        tick(ALL, 1'b1, 1'b0, 8'h41, 2'b11, 18'h0);
        tick(ALL, 1'b1, 1'b0, 8'h41, 2'b10, {9'h123, 9'h045});
        tick(ALL, 1'b0, 1'b0, 8'h41, 2'b11, {9'h0F0, 9'h1FF});
        chk("R6 upper lane only written", rdata, {9'h0F0, 9'h045});
        nop(18'h0);
    endtask

    task automatic t_select;
        flow_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            logic [2:0] s;
            s = ALL & ~(3'b001 << i);
            tick(s, 1'b1, 1'b0, 8'h41, 2'b11, 18'h0);
            nop(18'h3FFFF);
            tick(s, 1'b0, 1'b0, 8'h41, 2'b11, 18'h0);
            chk("R7 partial select not driven", {17'd0, rdata_oe}, 18'd0);
            tick(ALL, 1'b0, 1'b0, 8'h41, 2'b11, 18'h0);
            chk("R7 partial select write ignored", rdata, {9'h0F0, 9'h045});
        end
        nop(18'h0);
    endtask

    task automatic t_burst;
        logic [1:0] lo;
        flow_mode = 1'b1;
        tick(ALL, 1'b1, 1'b0, 8'h50, 2'b11, 18'h0);
        tick(ALL, 1'b1, 1'b0, 8'h51, 2'b11, 18'h00100);
        tick(ALL, 1'b1, 1'b0, 8'h52, 2'b11, 18'h00101);
        tick(ALL, 1'b1, 1'b0, 8'h53, 2'b11, 18'h00102);
        nop(18'h00103);
        interleave = 1'b0;
        for (int i = 0; i < 4; i++) begin
            lo = 2'd1 + 2'(i);
            if (i == 0) tick(ALL, 1'b0, 1'b0, 8'h51, 2'b11, 18'h0);
            else        tick(NON, 1'b0, 1'b1, 8'h00, 2'b11, 18'h0);
            chk("R8 linear beat", rdata, 18'h00100 + {16'd0, lo});
        end
        nop(18'h0);
        interleave = 1'b1;
        for (int i = 0; i < 4; i++) begin
            lo = 2'd1 ^ 2'(i);
            if (i == 0) tick(ALL, 1'b0, 1'b0, 8'h51, 2'b11, 18'h0);
            else        tick(NON, 1'b0, 1'b1, 8'h00, 2'b11, 18'h0);
            chk("R9 xor beat", rdata, 18'h00100 + {16'd0, lo});
        end
        nop(18'h0);
        interleave = 1'b0;
    endtask

    task automatic t_oe;
        flow_mode = 1'b1;
        tick(ALL, 1'b0, 1'b0, 8'h40, 2'b11, 18'h0);
        #1 oe_n = 1'b1;
        #1 chk("R10 async disable flag", {17'd0, rdata_oe}, 18'd0);
        chk("R10 async disable data", rdata, 18'd0);
        oe_n = 1'b0;
        #1 chk("R10 async re-enable", rdata, 18'h15A5A);
        @(negedge clk);
        nop(18'h0);
    endtask

    task automatic t_sleep;
        flow_mode = 1'b1;
        sleep = 1'b1;
        tick(ALL, 1'b1, 1'b0, 8'h40, 2'b11, 18'h0);
        nop(18'h3FFFF);
        tick(ALL, 1'b0, 1'b0, 8'h40, 2'b11, 18'h0);
        chk("R11 no drive while asleep", {17'd0, rdata_oe}, 18'd0);
        sleep = 1'b0;
        tick(ALL, 1'b0, 1'b0, 8'h40, 2'b11, 18'h0);
        chk("R11 write while asleep ignored", rdata, 18'h15A5A);
        #1 sleep = 1'b1;
        #1 chk("R11 async sleep drops drive", {17'd0, rdata_oe}, 18'd0);
        sleep = 1'b0;
        @(negedge clk);
        nop(18'h0);
    endtask

    task automatic t_clken;
        flow_mode = 1'b0;
        tick(ALL, 1'b0, 1'b0, 8'h10, 2'b11, 18'h0);
        clk_en = 1'b0;
        nop(18'h0);
        chk("R12 output held off while stalled", {17'd0, rdata_oe}, 18'd0);
        nop(18'h0);
        chk("R12 still held off", {17'd0, rdata_oe}, 18'd0);
        clk_en = 1'b1;
        nop(18'h0);
        chk("R12 delayed read drive", {17'd0, rdata_oe}, 18'd1);
        chk("R12 delayed read data", rdata, 18'h2A5A5);
        nop(18'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1-independent actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pipe_basic();
        t_pipe_fwd();
        t_flow();
        t_bytes();
        t_select();
        t_burst();
        t_oe();
        t_sleep();
        t_clken();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule